// File: doc/BRIEF.md
# Host interrupt request flag controller

This block drives the host-side interrupt request lines of a slave host-interface port. It produces two keyboard-style lines (IRQ1 and IRQ12), one system management interrupt line, and four shared lines (IRQ6, IRQ9, IRQ10, IRQ11). Each line is the OR of one or more enable bits held in three CPU-side control registers. The local CPU can raise an enable bit only by reading it as 0 and then writing 1. In the guarded case the CPU must also have written the paired data register since the host last read it.

A mode input chooses how the SMI and shared-line bits behave. With the mode at 0 they follow the guarded rules, and a host read of the paired data register drops them. With the mode at 1 they set on the read-0/write-1 pair alone and clear only by a CPU write of 0. IRQ1 and IRQ12 always follow the guarded rules, whatever the mode. The inputs are per-register strobes: CPU control reads and writes, CPU data-register writes and host data-register reads.

Top module: `hirq_ctrl`

## Requirements
- R1: After reset all interrupt outputs are low.
- R2: The IRQ1 bit (control register 0, bit 0) and the IRQ12 bit (control register 0, bit 1) set on a CPU write of 1 only when two conditions hold. Data register 0 must have been written since its last host read, and the bit must have been read as 0 since the last write to control register 0. This holds for either mode value.
- R3: IRQ1 and IRQ12 clear on a CPU write of 0 to their bit, or on a host read of data register 0, in either mode.
- R4: With the mode at 0, three SMI sources follow the same set rule as R2. Source A is control register 1 bit 0, paired with data register 1. Source B is control register 2 bit 0, paired with data register 2. Source C is control register 2 bit 1, paired with transfer register 3. A host read of the paired register clears the source.
- R5: With the mode at 0, shared line k (k = 0..3 for IRQ6, IRQ9, IRQ10, IRQ11) has two sources under the R4 rules. One is control register 1 bit 1+k, paired with data register 1. The other is control register 2 bit 2+k, paired with data register 2.
- R6: With the mode at 1, SMI and shared-line bits set on read-0 then write-1 with no data write needed. A host read never clears them, and a CPU write of 0 does. If the mode returns to 0 while a bit is pending, the next host read of its paired register clears it.
- R7: Writing 1 without a read-as-0 since the last write to that control register leaves the bit at 0. Any write to the register uses up the arm, and a read while the bit is 1 does not arm it.
- R8: When a host-read clear and a CPU set of the same bit fall in one cycle, the bit ends at 0.
- R9: smi_o is the OR of its three sources, and irqs_o[k] is the OR of its two sources. All outputs are active high and follow the enable bits one cycle after the strobe.
- R10: A host read of a data register cancels its written-since-read record. A set that relies on that register then needs a new data write. A data write and a host read of the same register in one cycle leave the record cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0: guarded SMI/shared rules; 1: unguarded |
| ctl_wr | input | 3 | One-hot CPU write strobe per control register |
| ctl_rd | input | 3 | One-hot CPU read strobe per control register |
| ctl_wdata | input | NSHR+2 | CPU write data for control registers |
| dat_wr | input | 4 | CPU write strobe per data register (index 3 = transfer register) |
| host_rd | input | 4 | Host read strobe per data register (index 3 = transfer register) |
| irq1_o | output | 1 | IRQ1 request |
| irq12_o | output | 1 | IRQ12 request |
| smi_o | output | 1 | System management interrupt request |
| irqs_o | output | NSHR | Shared lines IRQ6, IRQ9, IRQ10, IRQ11 (bit 0 = IRQ6) |

## Verification
Directed sequences try each enable bit in four orders: the full guarded order, a write of 1 with no read first, a read followed by a consuming write, and a host read that removes the data-write record. Comparing their results shows whether the arm and the written-since-read record are each needed. A same-cycle host read and set shows which of the two wins. Changing the mode between a set and a host read shows whether the clear depends on the current mode rather than on the mode at set time. Random cycles then mix strobes on all registers, so the OR of shared sources and any crosstalk between paired registers are compared against a bench model on every cycle.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int NCTL = 3;
  localparam int NSRC = 4;

  localparam int SRC_D0  = 0;
  localparam int SRC_D1  = 1;
  localparam int SRC_D2  = 2;
  localparam int SRC_T3  = 3;

  localparam int REG_KB  = 0;
  localparam int REG_A   = 1;
  localparam int REG_B   = 2;

  localparam int BIT_K1  = 0;
  localparam int BIT_K12 = 1;
  localparam int BIT_SMA = 0;
  localparam int BIT_SMB = 0;
  localparam int BIT_SMC = 1;
  localparam int SHA_LO  = 1;
  localparam int SHB_LO  = 2;
endpackage

// File: rtl/hirq_dflag.sv
module hirq_dflag (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic hrd_i,
  output logic pend_o
);
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_en = wr_i | hrd_i;
    pend_d  = pend_o;
    if (hrd_i)     pend_d = 1'b0;
    else if (wr_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_o <= 1'b0;
    else if (pend_en) pend_o <= pend_d;
  end
endmodule

// File: rtl/hirq_flag.sv
module hirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic guard_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic rd_i,
  input  logic dpend_i,
  input  logic hrd_i,
  output logic en_o
);
  logic arm_q, arm_d, arm_en;
  logic en_d, en_en;
  logic set_ok, clr;

  always_comb begin
    set_ok = wr_i & wbit_i & arm_q & (~guard_i | dpend_i);
    clr    = (guard_i & hrd_i) | (wr_i & ~wbit_i);
    en_en  = set_ok | clr;
    en_d   = clr ? 1'b0 : 1'b1;
    arm_en = wr_i | rd_i;
    arm_d  = wr_i ? 1'b0 : ~en_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o  <= 1'b0;
    end else if (en_en) begin
      en_o  <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
    end else if (arm_en) begin
      arm_q <= arm_d;
    end
  end
endmodule

// File: rtl/hirq_ctrl.sv
module hirq_ctrl
  import hirq_pkg::*;
#(
  parameter  int NSHR = 4,
  localparam int CW   = NSHR + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_i,
  input  logic [NCTL-1:0] ctl_wr,
  input  logic [NCTL-1:0] ctl_rd,
  input  logic [CW-1:0]   ctl_wdata,
  input  logic [NSRC-1:0] dat_wr,
  input  logic [NSRC-1:0] host_rd,
  output logic            irq1_o,
  output logic            irq12_o,
  output logic            smi_o,
  output logic [NSHR-1:0] irqs_o
);
  logic [NSRC-1:0] dpend;
  logic [1:0]      kb_en;
  logic [2:0]      smi_en;
  logic [NSHR-1:0] sha_en;
  logic [NSHR-1:0] shb_en;
  logic            g_var;

  assign g_var = ~mode_i;

  for (genvar s = 0; s < NSRC; s++) begin : g_dat
    hirq_dflag u_df (
      .clk(clk), .rst_n(rst_n),
      .wr_i(dat_wr[s]), .hrd_i(host_rd[s]),
      .pend_o(dpend[s])
    );
  end

  for (genvar k = 0; k < 2; k++) begin : g_kb
    localparam int B = (k == 0) ? BIT_K1 : BIT_K12;
    hirq_flag u_f (
      .clk(clk), .rst_n(rst_n), .guard_i(1'b1),
      .wr_i(ctl_wr[REG_KB]), .wbit_i(ctl_wdata[B]), .rd_i(ctl_rd[REG_KB]),
      .dpend_i(dpend[SRC_D0]), .hrd_i(host_rd[SRC_D0]),
      .en_o(kb_en[k])
    );
  end

  for (genvar m = 0; m < 3; m++) begin : g_smi
    localparam int R = (m == 0) ? REG_A : REG_B;
    localparam int B = (m == 0) ? BIT_SMA : ((m == 1) ? BIT_SMB : BIT_SMC);
    localparam int S = (m == 0) ? SRC_D1 : ((m == 1) ? SRC_D2 : SRC_T3);
    hirq_flag u_f (
      .clk(clk), .rst_n(rst_n), .guard_i(g_var),
      .wr_i(ctl_wr[R]), .wbit_i(ctl_wdata[B]), .rd_i(ctl_rd[R]),
      .dpend_i(dpend[S]), .hrd_i(host_rd[S]),
      .en_o(smi_en[m])
    );
  end

  for (genvar j = 0; j < NSHR; j++) begin : g_shr
    hirq_flag u_fa (
      .clk(clk), .rst_n(rst_n), .guard_i(g_var),
      .wr_i(ctl_wr[REG_A]), .wbit_i(ctl_wdata[SHA_LO+j]), .rd_i(ctl_rd[REG_A]),
      .dpend_i(dpend[SRC_D1]), .hrd_i(host_rd[SRC_D1]),
      .en_o(sha_en[j])
    );
    hirq_flag u_fb (
      .clk(clk), .rst_n(rst_n), .guard_i(g_var),
      .wr_i(ctl_wr[REG_B]), .wbit_i(ctl_wdata[SHB_LO+j]), .rd_i(ctl_rd[REG_B]),
      .dpend_i(dpend[SRC_D2]), .hrd_i(host_rd[SRC_D2]),
      .en_o(shb_en[j])
    );
  end

  assign irq1_o  = kb_en[0];
  assign irq12_o = kb_en[1];
  assign smi_o   = |smi_en;
  assign irqs_o  = sha_en | shb_en;
endmodule

// File: rtl/hirq_ctrl_chk.sv
module hirq_ctrl_chk
  import hirq_pkg::*;
#(
  parameter int NSHR = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_i,
  input logic [NCTL-1:0] ctl_wr,
  input logic [NSHR+1:0] ctl_wdata,
  input logic [NSRC-1:0] host_rd,
  input logic            irq1_o,
  input logic            irq12_o,
  input logic            smi_o,
  input logic [NSHR-1:0] irqs_o
);
  a_r3_cpu_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr[REG_KB] && !ctl_wdata[BIT_K1]) |=> !irq1_o);

  a_r3_host_clear: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd[SRC_D0] |=> (!irq1_o && !irq12_o));

  a_r2_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq1_o) |-> $past(ctl_wr[REG_KB] && ctl_wdata[BIT_K1]));

  a_r6_mode1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && !ctl_wr[REG_A] && !ctl_wr[REG_B]) |=> ($stable(smi_o) && $stable(irqs_o)));

  a_r9_smi_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_o) |-> $past(ctl_wr[REG_A] || ctl_wr[REG_B]));
endmodule

bind hirq_ctrl hirq_ctrl_chk #(.NSHR(NSHR)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ctl_wr(ctl_wr),
  .ctl_wdata(ctl_wdata), .host_rd(host_rd), .irq1_o(irq1_o),
  .irq12_o(irq12_o), .smi_o(smi_o), .irqs_o(irqs_o)
);

// File: tb/tb_hirq_ctrl.sv
`timescale 1ns/1ps
module tb_hirq_ctrl;
  localparam int NSHR = 4;
  localparam int CW   = NSHR + 2;
  localparam int NB   = 5 + 2 * NSHR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i = 1'b0;
  logic [2:0] ctl_wr = '0;
  logic [2:0] ctl_rd = '0;
  logic [CW-1:0] ctl_wdata = '0;
  logic [3:0] dat_wr = '0;
  logic [3:0] host_rd = '0;
  logic irq1_o, irq12_o, smi_o;
  logic [NSHR-1:0] irqs_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int  reg_of [NB];
  int  pos_of [NB];
  int  src_of [NB];
  bit  fix_of [NB];
  bit  m_en   [NB];
  bit  m_arm  [NB];
  bit  m_df   [4];

  always #2.5 clk = ~clk;

  hirq_ctrl #(.NSHR(NSHR)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .ctl_wdata(ctl_wdata), .dat_wr(dat_wr), .host_rd(host_rd),
    .irq1_o(irq1_o), .irq12_o(irq12_o), .smi_o(smi_o), .irqs_o(irqs_o)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [CW-1:0] regval(int r);
    logic [CW-1:0] v = '0;
    for (int i = 0; i < NB; i++) if (reg_of[i] == r) v[pos_of[i]] = m_en[i];
    return v;
  endfunction

  function automatic logic [NSHR+2:0] exp_out();
    logic [NSHR+2:0] v;
    v[NSHR+2] = m_en[0];
    v[NSHR+1] = m_en[1];
    v[NSHR]   = m_en[2] | m_en[3] | m_en[4];
    for (int j = 0; j < NSHR; j++) v[j] = m_en[5+j] | m_en[5+NSHR+j];
    return v;
  endfunction

  task automatic model_step();
    bit n_en [NB];
    bit n_arm[NB];
    for (int i = 0; i < NB; i++) begin
      bit g, rw, rr, wb, hr;
      g  = fix_of[i] | ~mode_i;
      rw = ctl_wr[reg_of[i]];
      rr = ctl_rd[reg_of[i]];
      wb = ctl_wdata[pos_of[i]];
      hr = host_rd[src_of[i]];
      if ((g && hr) || (rw && !wb))                       n_en[i] = 0;
      else if (rw && wb && m_arm[i] && (!g || m_df[src_of[i]])) n_en[i] = 1;
      else                                                n_en[i] = m_en[i];
      n_arm[i] = rw ? 1'b0 : (rr ? ~m_en[i] : m_arm[i]);
    end
    for (int i = 0; i < NB; i++) begin
      m_en[i]  = n_en[i];
      m_arm[i] = n_arm[i];
    end
    for (int s = 0; s < 4; s++)
      m_df[s] = host_rd[s] ? 1'b0 : (dat_wr[s] ? 1'b1 : m_df[s]);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R9 model", {irq1_o, irq12_o, smi_o, irqs_o}, exp_out());
    ctl_wr = '0; ctl_rd = '0; ctl_wdata = '0; dat_wr = '0; host_rd = '0;
  endtask

  task automatic cread(int r);  ctl_rd[r] = 1'b1; tick(); endtask
  task automatic cwrite(int r, logic [CW-1:0] d); ctl_wr[r] = 1'b1; ctl_wdata = d; tick(); endtask
  task automatic dwrite(int s); dat_wr[s] = 1'b1; tick(); endtask
  task automatic hread(int s);  host_rd[s] = 1'b1; tick(); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    reg_of[0] = 0; pos_of[0] = 0; src_of[0] = 0; fix_of[0] = 1;
    reg_of[1] = 0; pos_of[1] = 1; src_of[1] = 0; fix_of[1] = 1;
    reg_of[2] = 1; pos_of[2] = 0; src_of[2] = 1; fix_of[2] = 0;
    reg_of[3] = 2; pos_of[3] = 0; src_of[3] = 2; fix_of[3] = 0;
    reg_of[4] = 2; pos_of[4] = 1; src_of[4] = 3; fix_of[4] = 0;
    for (int j = 0; j < NSHR; j++) begin
      reg_of[5+j] = 1; pos_of[5+j] = 1 + j; src_of[5+j] = 1; fix_of[5+j] = 0;
      reg_of[5+NSHR+j] = 2; pos_of[5+NSHR+j] = 2 + j; src_of[5+NSHR+j] = 2; fix_of[5+NSHR+j] = 0;
    end
    for (int i = 0; i < NB; i++) begin m_en[i] = 0; m_arm[i] = 0; end
    for (int s = 0; s < 4; s++) m_df[s] = 0;
    void'($urandom(32'h1234_5eed));

    repeat (3) @(negedge clk);
    chk("R1 reset", {irq1_o, irq12_o, smi_o, irqs_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {irq1_o, irq12_o, smi_o, irqs_o}, '0);

    // R2 guarded set of IRQ1
    dwrite(0); cread(0); cwrite(0, 6'b000001);
    chk("R2 irq1 set", irq1_o, 1);
    cwrite(0, 6'b000001);
    chk("R2 irq1 held", irq1_o, 1);
    hread(0);
    chk("R3 irq1 host clear", irq1_o, 0);

    // R7 arm handling on IRQ12
    dwrite(0); cwrite(0, 6'b000010);
    chk("R7 no read before write", irq12_o, 0);
    cread(0); cwrite(0, 6'b000000); cwrite(0, 6'b000010);
    chk("R7 arm consumed", irq12_o, 0);
    cread(0); cwrite(0, 6'b000010);
    chk("R2 irq12 set", irq12_o, 1);
    cwrite(0, 6'b000000);
    chk("R3 irq12 cpu clear", irq12_o, 0);

    // R2 keyboard bits stay guarded in mode 1
    hread(0); mode_i = 1'b1;
    cread(0); cwrite(0, 6'b000001);
    chk("R2 irq1 mode1 needs data", irq1_o, 0);

    // R4 SMI source C
    mode_i = 1'b0;
    dwrite(3); cread(2); cwrite(2, 6'b000010);
    chk("R4 smi C set", smi_o, 1);
    hread(3);
    chk("R4 smi C host clear", smi_o, 0);

    // R10 stale data record
    cread(2); cwrite(2, 6'b000010);
    chk("R10 record cancelled", smi_o, 0);

    // R5 shared IRQ10 via second source
    dwrite(2); cread(2); cwrite(2, 6'b010000);
    chk("R5 irq10 set", irqs_o, 4'b0100);
    hread(2);
    chk("R5 irq10 host clear", irqs_o, 4'b0000);

    // R6 mode 1 and mode toggle while pending
    mode_i = 1'b1;
    cread(1); cwrite(1, 6'b000001);
    chk("R6 smi set no data", smi_o, 1);
    hread(1);
    chk("R6 host read ignored", smi_o, 1);
    mode_i = 1'b0; tick();
    chk("R6 toggle keeps pending", smi_o, 1);
    hread(1);
    chk("R6 clear after toggle", smi_o, 0);

    // R8 same-cycle set and host clear
    dwrite(1); cread(1);
    ctl_wr[1] = 1'b1; ctl_wdata = 6'b000010; host_rd[1] = 1'b1; tick();
    chk("R8 clear wins", irqs_o, 4'b0000);

    // R9 OR of two sources
    mode_i = 1'b1;
    cread(1); cwrite(1, 6'b000010);
    cread(2); cwrite(2, 6'b000100);
    chk("R9 both sources", irqs_o, 4'b0001);
    cwrite(1, 6'b000000);
    chk("R9 one source left", irqs_o, 4'b0001);
    cwrite(2, 6'b000000);
    chk("R9 none left", irqs_o, 4'b0000);

    // random mix against the model
    for (int c = 0; c < 4000; c++) begin
      int op, r;
      op = $urandom % 8;
      r  = $urandom % 3;
      if ($urandom % 16 == 0) mode_i = ~mode_i;
      dat_wr  = 4'($urandom) & 4'($urandom);
      host_rd = 4'($urandom) & 4'($urandom) & 4'($urandom);
      if (op < 3) ctl_rd[r] = 1'b1;
      else if (op < 6) begin
        ctl_wr[r] = 1'b1;
        ctl_wdata = (op == 5) ? CW'($urandom) : (regval(r) ^ CW'(1 << ($urandom % CW)));
      end
      tick();
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule